// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a small, fully associative address translation cache. Every entry describes two neighbouring virtual pages, one even and one odd, that share a single tag. Each page has its own physical frame and its own valid and dirty bits. A per-entry size mask widens both pages together, from 4 KB upwards. An entry either belongs to one 8-bit address-space identifier or is marked global, in which case it applies to every address space.

A lookup request carries a 32-bit virtual address, a write flag and the current address-space identifier. One clock later the block returns a result code, the physical address and a write-permission flag. The result code is one of four values: hit, invalid page, write to a clean page, or miss. A plain indexed write port loads whole entries. The choice of which entry to replace, and the handling of a miss, belong to the surrounding logic.

Top module: `pptlb_lookup`

## Requirements
- R1: An entry takes part in a lookup only if its global flag is set or its stored identifier equals `req_asid`, and its tag equals the request address in every bit that lies outside the entry's effective mask.
- R2: The effective mask always covers address bits 12..0, so one pair spans at least 8 KB. Bit i of `wr_pmask` adds address bit 13+i. Addresses one byte past the end of a pair miss.
- R3: The even or odd page is chosen by the highest address bit under the effective mask. That is bit 12 for 4 KB pages and bit 14 when `wr_pmask` is 2'b11.
- R4: If the chosen page's valid bit is clear, the code is 1 (invalid), for reads and for writes alike.
- R5: A write to a valid page whose dirty bit is clear gives code 2 (modified). A read of the same page gives code 0 (hit).
- R6: On a hit, `rsp_pa` is the chosen frame number placed at bit 12, ORed with the request address bits that lie under the effective mask shifted right by one.
- R7: On a hit, `rsp_wr_ok` equals the chosen page's dirty bit. For every other code, `rsp_wr_ok` is 0 and `rsp_pa` is 0.
- R8: When no entry takes part, the code is 3 (miss).
- R9: When several entries take part, the one with the lowest index decides the result.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. An entry written in one cycle is seen by a request made in the next cycle.
- R11: Reset clears `rsp_valid` and sets every entry field to zero. An all-zero entry therefore answers address space 0 at tag 0 with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn | input | 19 | Tag: virtual address bits 31..13 |
| wr_asid | input | 8 | Owning address-space identifier |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pmask | input | 16 | Size mask over address bits 28..13 |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_v_even | input | 1 | Even page valid |
| wr_v_odd | input | 1 | Odd page valid |
| wr_d_even | input | 1 | Even page writable (dirty) |
| wr_d_odd | input | 1 | Odd page writable (dirty) |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Result present |
| rsp_code | output | 2 | 0 hit, 1 invalid, 2 modified, 3 miss |
| rsp_pa | output | 32 | Physical address |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
A corrupted tag, mask or identifier shows up one cycle after the next request that touches that entry, as a wrong code or a wrong physical address. A wrong half-select bit appears only for addresses whose offset bits sit just below the page-size boundary. For that reason the bench probes addresses on both sides of bit 12 and bit 14. A stale entry after a write appears at the very next request, and an error in the priority order appears only when two entries overlap. Both cases are set up on purpose.

// File: rtl/pptlb_pkg.sv
package pptlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PAIR_SHIFT = PAGE_SHIFT + 1;
  localparam int VPN_W      = VA_W - PAIR_SHIFT;
  localparam int MASK_W     = 16;
  localparam int PFN_W      = VA_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;

  typedef enum logic [1:0] {
    RES_HIT      = 2'd0,
    RES_INVALID  = 2'd1,
    RES_MODIFIED = 2'd2,
    RES_MISS     = 2'd3
  } res_code_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [MASK_W-1:0] pmask;
    logic [PFN_W-1:0]  pfn_even;
    logic [PFN_W-1:0]  pfn_odd;
    logic              v_even;
    logic              v_odd;
    logic              d_even;
    logic              d_odd;
  } tlb_entry_t;

  // Effective pair mask: fixed low 8 KB span plus the programmable size bits.
  function automatic logic [VA_W-1:0] span_mask(input logic [MASK_W-1:0] pm);
    logic [VA_W-1:0] m;
    m = '0;
    m[PAIR_SHIFT-1:0] = '1;
    m[PAIR_SHIFT +: MASK_W] = pm;
    return m;
  endfunction
endpackage

// File: rtl/pptlb_pair_match.sv
module pptlb_pair_match
  import pptlb_pkg::*;
(
  input  tlb_entry_t        ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic              half_valid,
  output logic              half_dirty,
  output logic [VA_W-1:0]   pa
);
  logic [VA_W-1:0] m;
  logic [VA_W-1:0] half_m;
  logic [VA_W-1:0] tag_full;
  logic            odd;

  always_comb begin
    m        = span_mask(ent.pmask);
    half_m   = m >> 1;
    tag_full = {ent.vpn, {PAIR_SHIFT{1'b0}}};
    hit      = (ent.glob || (ent.asid == asid)) && ((tag_full & ~m) == (va & ~m));
    odd      = |(va & m & ~half_m);
    half_valid = odd ? ent.v_odd : ent.v_even;
    half_dirty = odd ? ent.d_odd : ent.d_even;
    pa       = {(odd ? ent.pfn_odd : ent.pfn_even), {PAGE_SHIFT{1'b0}}} | (va & half_m);
  end
endmodule

// File: rtl/pptlb_first_hit.sv
module pptlb_first_hit #(
  parameter  int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pptlb_lookup.sv
module pptlb_lookup
  import pptlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [MASK_W-1:0] wr_pmask,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_v_odd,
  input  logic              wr_d_even,
  input  logic              wr_d_odd,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [VA_W-1:0]   rsp_pa,
  output logic              rsp_wr_ok
);
  tlb_entry_t      tbl [ENTRIES];
  logic [ENTRIES-1:0] hit_v;
  logic [ENTRIES-1:0] hv_v;
  logic [ENTRIES-1:0] hd_v;
  logic [VA_W-1:0] pa_v [ENTRIES];
  logic            sel_any;
  logic [IW-1:0]   sel_idx;
  res_code_e       nxt_code;
  logic [VA_W-1:0] nxt_pa;
  logic            nxt_ok;

  // Entry storage: indexed write, visible to lookups from the next cycle (R10, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
      tbl[wr_idx] <= '{vpn: wr_vpn, asid: wr_asid, glob: wr_global, pmask: wr_pmask,
                       pfn_even: wr_pfn_even, pfn_odd: wr_pfn_odd,
                       v_even: wr_v_even, v_odd: wr_v_odd,
                       d_even: wr_d_even, d_odd: wr_d_odd};
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    pptlb_pair_match u_match (
      .ent        (tbl[g]),
      .va         (req_va),
      .asid       (req_asid),
      .hit        (hit_v[g]),
      .half_valid (hv_v[g]),
      .half_dirty (hd_v[g]),
      .pa         (pa_v[g])
    );
  end

  pptlb_first_hit #(.N(ENTRIES)) u_first (
    .hits (hit_v),
    .any  (sel_any),
    .idx  (sel_idx)
  );

  always_comb begin
    nxt_code = RES_MISS;
    nxt_pa   = '0;
    nxt_ok   = 1'b0;
    if (sel_any) begin
      if (!hv_v[sel_idx]) begin
        nxt_code = RES_INVALID;
      end else if (req_write && !hd_v[sel_idx]) begin
        nxt_code = RES_MODIFIED;
      end else begin
        nxt_code = RES_HIT;
        nxt_pa   = pa_v[sel_idx];
        nxt_ok   = hd_v[sel_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RES_MISS;
      rsp_pa    <= '0;
      rsp_wr_ok <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= nxt_code;
        rsp_pa    <= nxt_pa;
        rsp_wr_ok <= nxt_ok;
      end
    end
  end

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r7_wr_ok_only_hit: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr_ok) |-> (rsp_code == RES_HIT));
  a_r5_modified_needs_store: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RES_MODIFIED) |-> $past(req_write));
  a_r8_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RES_HIT) |-> (rsp_pa == '0 && !rsp_wr_ok));
endmodule

// File: tb/pptlb_lookup_tb.sv
module pptlb_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [15:0] wr_pmask = '0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic        wr_v_even = 1'b0, wr_v_odd = 1'b0, wr_d_even = 1'b0, wr_d_odd = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic        rsp_wr_ok;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pptlb_lookup dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_pmask(wr_pmask),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_v_even(wr_v_even), .wr_v_odd(wr_v_odd), .wr_d_even(wr_d_even), .wr_d_odd(wr_d_odd),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] va, input logic [7:0] asid,
                     input logic g, input logic [15:0] pm,
                     input logic [19:0] pe, input logic [19:0] po,
                     input logic ve, input logic vo, input logic de, input logic dd);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = va[31:13]; wr_asid = asid; wr_global = g;
    wr_pmask = pm; wr_pfn_even = pe; wr_pfn_odd = po;
    wr_v_even = ve; wr_v_odd = vo; wr_d_even = de; wr_d_odd = dd;
  endtask

  // Issue a lookup at a falling edge, sample the result at the next falling edge.
  task automatic look(input string tag, input logic [31:0] va, input logic wr, input logic [7:0] asid,
                      input logic [1:0] ecode, input logic [31:0] epa, input logic eok);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_va = va; req_write = wr; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " code"}, 32'(rsp_code), 32'(ecode));
    chk({tag, " pa"}, rsp_pa, epa);
    chk({tag, " wr_ok"}, 32'(rsp_wr_ok), 32'(eok));
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    look("R11 zero entry asid0", 32'h0000_0010, 1'b0, 8'h00, 2'd1, 32'h0, 1'b0);
    look("R11 R8 zero entry other asid", 32'h0000_0010, 1'b0, 8'h05, 2'd3, 32'h0, 1'b0);
    @(negedge clk);
    chk("R10 idle no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_small_pages;
    put(2, 32'h0040_0000, 8'h21, 1'b0, 16'h0, 20'h12345, 20'h6789A, 1'b1, 1'b1, 1'b1, 1'b0);
    look("R1 R6 R7 even read", 32'h0040_0123, 1'b0, 8'h21, 2'd0, 32'h1234_5123, 1'b1);
    look("R3 R5 odd store clean", 32'h0040_1ABC, 1'b1, 8'h21, 2'd2, 32'h0, 1'b0);
    look("R5 R6 R7 odd read clean", 32'h0040_1ABC, 1'b0, 8'h21, 2'd0, 32'h6789_AABC, 1'b0);
    look("R1 R8 foreign asid", 32'h0040_0123, 1'b0, 8'h22, 2'd3, 32'h0, 1'b0);
    look("R2 R8 past pair end", 32'h0040_2000, 1'b0, 8'h21, 2'd3, 32'h0, 1'b0);
  endtask

  task automatic t_big_pages;
    put(3, 32'h0100_0000, 8'h00, 1'b1, 16'h0003, 20'h0AAA0, 20'h0BBB4, 1'b0, 1'b1, 1'b0, 1'b1);
    look("R1 R3 R6 global odd 16K", 32'h0100_5678, 1'b1, 8'h77, 2'd0, 32'h0BBB_5678, 1'b1);
    look("R3 R4 bit13 set still even", 32'h0100_3FFF, 1'b0, 8'h10, 2'd1, 32'h0, 1'b0);
    look("R4 invalid on store", 32'h0100_1234, 1'b1, 8'h10, 2'd1, 32'h0, 1'b0);
    look("R2 top of pair", 32'h0100_7FFF, 1'b0, 8'h01, 2'd0, 32'h0BBB_7FFF, 1'b1);
    look("R2 R8 one past pair", 32'h0100_8000, 1'b0, 8'h01, 2'd3, 32'h0, 1'b0);
  endtask

  task automatic t_priority;
    put(9, 32'h0200_0000, 8'h00, 1'b1, 16'h0, 20'h99999, 20'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    put(5, 32'h0200_0000, 8'h00, 1'b1, 16'h0, 20'h55555, 20'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    look("R9 lowest index wins", 32'h0200_0010, 1'b0, 8'h33, 2'd0, 32'h5555_5010, 1'b1);
    put(5, 32'h0300_0000, 8'h00, 1'b1, 16'h0, 20'h55555, 20'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    look("R10 R9 rewrite seen next cycle", 32'h0200_0010, 1'b0, 8'h33, 2'd0, 32'h9999_9010, 1'b1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_small_pages();
    t_big_pages();
    t_priority();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule